// File: doc/BRIEF.md
# Strobe-Gated Serial Converter Readback Controller

This block is the host-side sequencer for a 12-bit serial analog-to-digital converter that runs its conversions from its own internal clock. When the system raises a start request, the controller pulls chip select low and sends an 8-bit command byte on its serial data output, most significant bit first. It then parks the serial clock at its low idle level and watches the converter's conversion strobe. A low strobe means a conversion is running. A return to high means the result is ready.

Once the strobe has returned high, the controller generates a fresh serial clock. It collects the 12 result bits, most significant first, and raises chip select again. The result is presented with a one-cycle valid pulse. A cycle-counting watchdog guards the wait for the strobe. If the conversion never finishes within the programmed bound, the controller gives up, releases chip select and pulses a timeout flag. The system sees a plain start / busy / valid / data handshake. The serial clock half-period is set in system-clock cycles, so the readback rate can go as slow as needed.

Top module: `convReadCtrl`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, and `busy`, `resValid` and `timeoutPulse` are 0.
- R2: A `startReq` seen while idle makes `busy` 1 and `csN` 0 from the next cycle on. A `startReq` seen while `busy` is 1 is ignored: no second transaction follows.
- R3: The 8 bits of `cmdByte` appear on `dinOut` most significant bit first, each valid at a rising `sclk` edge. There are exactly 8 rising edges before the conversion wait.
- R4: Every `sclk` level lasts `HALF_DIV` system-clock cycles while `sclk` is running, so a full period is `2*HALF_DIV` cycles.
- R5: While the conversion strobe is low, `sclk` stays at 0 and makes no edge.
- R6: After the strobe has gone low and then high again, `sclk` makes 13 rising edges. The first rising edge captures nothing. Each of the following 12 rising edges samples `doutIn`, which the converter changed on the falling edge just before it. The first sampled bit becomes `result[11]` and the last becomes `result[0]`.
- R7: After the last falling `sclk` edge, `resValid` is 1 for exactly one cycle. In that same cycle `result` holds the word, `busy` is 0 and `csN` is 1.
- R8: The wait starts in the cycle after the 8th falling command edge. If no completion is seen within `TIMEOUT_CYC` cycles of that start, `timeoutPulse` is 1 for one cycle, `busy` falls, `csN` rises and no `resValid` is given. With the strobe held low, `timeoutPulse` is seen `TIMEOUT_CYC` cycles after the first wait cycle.
- R9: If a synchronised strobe rise and the last wait cycle fall in the same cycle, completion wins. The readback then proceeds and `timeoutPulse` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start a transaction (sampled while idle) |
| cmdByte | input | CMD_W | Command byte sent to the converter |
| busy | output | 1 | Transaction in progress |
| resValid | output | 1 | One-cycle pulse: `result` is new |
| result | output | RES_W | Last conversion word |
| timeoutPulse | output | 1 | One-cycle pulse: conversion wait expired |
| csN | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| dinOut | output | 1 | Serial command data to the converter |
| doutIn | input | 1 | Serial result data from the converter |
| strobeIn | input | 1 | Converter busy/done strobe (low while converting) |

## Verification
Completion of the conversion and expiry of the wait timer can both be decided in the same cycle. The bench provokes this by raising the strobe `TIMEOUT_CYC-3` cycles after it set the strobe low. The two synchroniser flops then carry the rise into the timer's final wait cycle. A pass at that offset needs a valid pulse with the correct word and no timeout pulse. The bench also raises the strobe one cycle later and expects the opposite: a timeout pulse, no valid pulse, and `csN` released.

// File: rtl/convReadPkg.sv
package convReadPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_READ = 2'd3
  } rdState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic divRun;     // serial clock divider active
    logic driveCmd;   // put command MSB on dinOut
    logic loadCmd;    // load command shift register
    logic shiftCmd;   // advance command shift register
    logic sclkHigh;   // drive serial clock high
    logic sclkLow;    // drive serial clock low
    logic captureBit; // shift doutIn into result register
    logic clrBits;    // clear bit counter
    logic countBit;   // increment bit counter
    logic timerRun;   // wait timer counting
    logic publish;    // copy assembled word to output
  } ctlStrobes_t;

endpackage

// File: rtl/convReadDatapath.sv
module convReadDatapath
  import convReadPkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int RES_W       = 12,
  parameter int HALF_DIV    = 13,
  parameter int TIMEOUT_CYC = 550,
  parameter int SYNC_STAGES = 2,
  parameter int BIT_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [CMD_W-1:0]  cmdByte,
  input  logic              doutIn,
  input  logic              strobeIn,
  output logic              tick,
  output logic              sclk,
  output logic              dinOut,
  output logic              strbSync,
  output logic              timerHit,
  output logic [BIT_W-1:0]  bitCnt,
  output logic [RES_W-1:0]  result
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int TMR_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  logic [DIV_W-1:0]       divCnt;
  logic                   sclkReg;
  logic [CMD_W-1:0]       cmdShift;
  logic [RES_W-1:0]       resShift;
  logic [TMR_W-1:0]       timer;
  logic [SYNC_STAGES-1:0] syncChain;

  // serial clock half-period divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!ctl.divRun) begin
      divCnt <= '0;
    end else if (divCnt == DIV_LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick = ctl.divRun && (divCnt == DIV_LAST);

  // serial clock level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkReg <= 1'b0;
    end else if (ctl.sclkHigh) begin
      sclkReg <= 1'b1;
    end else if (ctl.sclkLow) begin
      sclkReg <= 1'b0;
    end
  end

  assign sclk = sclkReg;

  // command shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift <= '0;
    end else if (ctl.loadCmd) begin
      cmdShift <= cmdByte;
    end else if (ctl.shiftCmd) begin
      cmdShift <= {cmdShift[CMD_W-2:0], 1'b0};
    end
  end

  assign dinOut = ctl.driveCmd & cmdShift[CMD_W-1];

  // result assembly, MSB arrives first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resShift <= '0;
    end else if (ctl.captureBit) begin
      resShift <= {resShift[RES_W-2:0], doutIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (ctl.publish) begin
      result <= resShift;
    end
  end

  // bit counter shared by command and readback phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ctl.clrBits) begin
      bitCnt <= '0;
    end else if (ctl.countBit) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // conversion wait timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (!ctl.timerRun) begin
      timer <= '0;
    end else if (timer != TMR_LAST) begin
      timer <= timer + 1'b1;
    end
  end

  assign timerHit = ctl.timerRun && (timer == TMR_LAST);

  // strobe synchroniser, idles high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= strobeIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], strobeIn};
      end
    end
  endgenerate

  assign strbSync = syncChain[SYNC_STAGES-1];

  // R4: serial clock only moves on a divider tick
  p_sclk_on_tick_r4 : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclkReg) |-> $past(tick));

  // R8: wait timer never passes its final count
  p_timer_bound_r8 : assert property (@(posedge clk) disable iff (!rstN)
    timer <= TMR_LAST);

endmodule

// File: rtl/convReadFsm.sv
module convReadFsm
  import convReadPkg::*;
#(
  parameter int CMD_W = 8,
  parameter int RES_W = 12,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             tick,
  input  logic             sclkLvl,
  input  logic             strbSync,
  input  logic             timerHit,
  input  logic [BIT_W-1:0] bitCnt,
  output ctlStrobes_t      ctl,
  output logic             busy,
  output logic             csN,
  output logic             resValid,
  output logic             timeoutPulse
);

  localparam logic [BIT_W-1:0] CMD_LAST = BIT_W'(CMD_W);
  localparam logic [BIT_W-1:0] RES_LAST = BIT_W'(RES_W);

  rdState_t state, stNext;
  logic     seenLow, seenLowNext;
  logic     readFell, fellNext;
  logic     toNext;

  always_comb begin
    ctl         = '0;
    stNext      = state;
    seenLowNext = seenLow;
    fellNext    = readFell;
    toNext      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        seenLowNext = 1'b0;
        if (startReq) begin
          ctl.loadCmd = 1'b1;
          ctl.clrBits = 1'b1;
          stNext      = ST_CMD;
        end
      end
      ST_CMD: begin
        ctl.divRun   = 1'b1;
        ctl.driveCmd = 1'b1;
        if (tick) begin
          if (!sclkLvl) begin
            ctl.sclkHigh = 1'b1;
            ctl.countBit = 1'b1;
          end else begin
            ctl.sclkLow = 1'b1;
            if (bitCnt == CMD_LAST) begin
              ctl.clrBits = 1'b1;
              stNext      = ST_WAIT;
            end else begin
              ctl.shiftCmd = 1'b1;
            end
          end
        end
      end
      ST_WAIT: begin
        ctl.timerRun = 1'b1;
        if (!strbSync) seenLowNext = 1'b1;
        // completion takes priority over timer expiry
        if (strbSync && seenLow) begin
          fellNext    = 1'b0;
          ctl.clrBits = 1'b1;
          stNext      = ST_READ;
        end else if (timerHit) begin
          toNext = 1'b1;
          stNext = ST_IDLE;
        end
      end
      ST_READ: begin
        ctl.divRun = 1'b1;
        if (tick) begin
          if (!sclkLvl) begin
            ctl.sclkHigh = 1'b1;
            if (readFell) begin
              ctl.captureBit = 1'b1;
              ctl.countBit   = 1'b1;
            end
          end else begin
            ctl.sclkLow = 1'b1;
            if (bitCnt == RES_LAST) begin
              ctl.publish = 1'b1;
              stNext      = ST_IDLE;
            end else begin
              fellNext = 1'b1;
            end
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      seenLow      <= 1'b0;
      readFell     <= 1'b0;
      resValid     <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      state        <= stNext;
      seenLow      <= seenLowNext;
      readFell     <= fellNext;
      resValid     <= ctl.publish;
      timeoutPulse <= toNext;
    end
  end

  assign busy = (state != ST_IDLE);
  assign csN  = (state == ST_IDLE);

  // R2: idle start opens a command phase
  p_start_opens_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> (state == ST_CMD));

  // R5: serial clock parked low during the wait
  p_sclk_idle_wait_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> !sclkLvl);

  // R7: valid is a single-cycle pulse
  p_valid_pulse_r7 : assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R9: a transaction ends in exactly one outcome
  p_one_outcome_r9 : assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && timeoutPulse));

  // R8: timeout ends the transaction
  p_timeout_idle_r8 : assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> (!busy && csN));

endmodule

// File: rtl/convReadCtrl.sv
module convReadCtrl
  import convReadPkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int RES_W       = 12,
  parameter int HALF_DIV    = 13,
  parameter int TIMEOUT_CYC = 550,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CMD_W-1:0] cmdByte,
  output logic             busy,
  output logic             resValid,
  output logic [RES_W-1:0] result,
  output logic             timeoutPulse,
  output logic             csN,
  output logic             sclk,
  output logic             dinOut,
  input  logic             doutIn,
  input  logic             strobeIn
);

  localparam int MAX_BITS = (CMD_W > RES_W) ? CMD_W : RES_W;
  localparam int BIT_W    = $clog2(MAX_BITS + 1);

  ctlStrobes_t      ctl;
  logic             tick;
  logic             strbSync;
  logic             timerHit;
  logic [BIT_W-1:0] bitCnt;

  convReadFsm #(
    .CMD_W(CMD_W), .RES_W(RES_W), .BIT_W(BIT_W)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tick(tick),
    .sclkLvl(sclk), .strbSync(strbSync), .timerHit(timerHit),
    .bitCnt(bitCnt), .ctl(ctl), .busy(busy), .csN(csN),
    .resValid(resValid), .timeoutPulse(timeoutPulse)
  );

  convReadDatapath #(
    .CMD_W(CMD_W), .RES_W(RES_W), .HALF_DIV(HALF_DIV),
    .TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES), .BIT_W(BIT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdByte(cmdByte),
    .doutIn(doutIn), .strobeIn(strobeIn), .tick(tick), .sclk(sclk),
    .dinOut(dinOut), .strbSync(strbSync), .timerHit(timerHit),
    .bitCnt(bitCnt), .result(result)
  );

endmodule

// File: tb/convReadCtrl_tb.sv
module convReadCtrl_tb;

  localparam int HALF_DIV = 13;
  localparam int LIMIT    = 550;
  localparam int NVEC     = 6;

  // {command, result word, strobe-low cycles}
  localparam logic [35:0] VEC [NVEC] = '{
    {8'h8F, 12'hA5C, 16'd5},
    {8'hC1, 12'hFFF, 16'd40},
    {8'h01, 12'h000, 16'd200},
    {8'hB7, 12'h801, 16'd480},
    {8'h5A, 12'h3C6, 16'd60},
    {8'hFE, 12'h7FE, 16'd4}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  cmdByte = '0;
  logic        busy, resValid, timeoutPulse, csN, sclk, dinOut;
  logic [11:0] result;
  logic        doutIn = 1'b0;
  logic        strobeIn = 1'b1;

  int checks = 0;
  int fails = 0;
  int convEdges = 0;
  logic sclkPrev = 1'b0;
  logic strbPrev = 1'b1;

  always #10 clk = ~clk;

  convReadCtrl #(.HALF_DIV(HALF_DIV), .TIMEOUT_CYC(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdByte(cmdByte),
    .busy(busy), .resValid(resValid), .result(result),
    .timeoutPulse(timeoutPulse), .csN(csN), .sclk(sclk), .dinOut(dinOut),
    .doutIn(doutIn), .strobeIn(strobeIn)
  );

  // R5 monitor: serial clock edges while the strobe has been low
  always @(posedge clk) begin
    if (!strobeIn && !strbPrev && (sclk != sclkPrev)) convEdges++;
    sclkPrev <= sclk;
    strbPrev <= strobeIn;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=1 exp=0");
    finishRun();
  end

  // one full transaction; the bench plays the converter
  task automatic runTxn(input logic [7:0] cmd, input logic [11:0] val, input int k,
                        input bit neverRise, input bit poke,
                        output logic [7:0] gotCmd, output bit sawValid,
                        output bit sawTimeout, output int waitCnt, output time halfT);
    time t1, t2;
    gotCmd = '0;
    sawValid = 0;
    sawTimeout = 0;
    waitCnt = 0;
    t1 = 0;
    t2 = 0;
    doutIn = ~val[11];
    @(negedge clk);
    cmdByte = cmd;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    cmdByte = 8'h00;
    check(busy == 1'b1 && csN == 1'b0, "R2 start busy/csN", {busy, csN}, 2'b10);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk);
      gotCmd = {gotCmd[6:0], dinOut};
      if (i == 0) t1 = $time;
      if (i == 1) t2 = $time;
    end
    halfT = (t2 - t1) / 2;
    @(negedge sclk);
    @(negedge clk);
    strobeIn = 1'b0;
    fork
      begin
        if (!neverRise) begin
          if (poke) begin
            @(negedge clk);
            startReq = 1'b1;
            cmdByte = 8'hFF;
            @(negedge clk);
            startReq = 1'b0;
            repeat (k - 2) @(negedge clk);
          end else begin
            repeat (k) @(negedge clk);
          end
          strobeIn = 1'b1;
          for (int b = 0; b < 12; b++) begin
            if (csN) break;
            @(negedge sclk or posedge csN);
            if (csN) break;
            doutIn = val[11-b];
          end
        end
      end
      begin
        while (!sawValid && !sawTimeout && waitCnt < 3000) begin
          @(negedge clk);
          waitCnt++;
          if (resValid) sawValid = 1;
          if (timeoutPulse) sawTimeout = 1;
        end
      end
    join
    strobeIn = 1'b1;
  endtask

  initial begin
    logic [7:0] gotCmd;
    bit sv, st;
    int wc;
    time halfT;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(csN == 1'b1, "R1 csN", csN, 1);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    check(busy == 1'b0 && resValid == 1'b0 && timeoutPulse == 1'b0, "R1 flags",
          {busy, resValid, timeoutPulse}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && busy == 1'b0, "R1 idle after release", {csN, busy}, 2'b10);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      runTxn(VEC[v][35:28], VEC[v][27:16], int'(VEC[v][15:0]), 0, 0, gotCmd, sv, st, wc, halfT);
      check(gotCmd == VEC[v][35:28], "R3 command bits", gotCmd, VEC[v][35:28]);
      check(halfT == HALF_DIV * 20, "R4 half period", int'(halfT), HALF_DIV * 20);
      check(sv && !st, "R7 valid without timeout", {sv, st}, 2'b10);
      check(result == VEC[v][27:16], "R6 result word", result, VEC[v][27:16]);
      check(busy == 1'b0 && csN == 1'b1, "R7 released with valid", {busy, csN}, 2'b01);
      @(negedge clk);
      check(resValid == 1'b0, "R7 valid one cycle", resValid, 0);
      repeat (5) @(negedge clk);
    end
    check(convEdges == 0, "R5 no sclk edge while converting", convEdges, 0);

    // R2: start while busy ignored
    runTxn(8'h93, 12'h5A3, 30, 0, 1, gotCmd, sv, st, wc, halfT);
    check(sv && result == 12'h5A3, "R2 poke leaves txn intact", result, 12'h5A3);
    repeat (40) @(negedge clk);
    check(busy == 1'b0 && csN == 1'b1, "R2 no second txn", {busy, csN}, 2'b01);

    // R8: strobe never returns high
    runTxn(8'h44, 12'h123, 0, 1, 0, gotCmd, sv, st, wc, halfT);
    check(st && !sv, "R8 timeout raised", {st, sv}, 2'b10);
    check(wc == LIMIT, "R8 timeout timing", wc, LIMIT);
    check(busy == 1'b0 && csN == 1'b1 && sclk == 1'b0, "R8 released", {busy, csN, sclk}, 3'b010);
    @(negedge clk);
    check(timeoutPulse == 1'b0, "R8 timeout one cycle", timeoutPulse, 0);
    repeat (5) @(negedge clk);

    // R9: rise lands on the last wait cycle -> completion wins
    runTxn(8'h2D, 12'hC3A, LIMIT - 3, 0, 0, gotCmd, sv, st, wc, halfT);
    check(sv && !st, "R9 completion wins tie", {sv, st}, 2'b10);
    check(result == 12'hC3A, "R9 result after tie", result, 12'hC3A);
    repeat (5) @(negedge clk);

    // R8: rise one cycle too late -> timeout
    runTxn(8'h71, 12'h0F0, LIMIT - 2, 0, 0, gotCmd, sv, st, wc, halfT);
    check(st && !sv, "R8 late rise times out", {st, sv}, 2'b10);
    check(result == 12'hC3A, "R8 result unchanged on timeout", result, 12'hC3A);
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && csN == 1'b1, "R8 stays idle", {busy, csN}, 2'b01);
    check(convEdges == 0, "R5 no edge in any wait", convEdges, 0);

    finishRun();
  end

endmodule